// File: doc/BRIEF.md
# Multiplier-Free 8-Point DCT Engine

This block turns a set of eight signed samples into the eight coefficients of a one-dimensional discrete cosine transform. No multiplier is used anywhere. Each cosine weight is held as a 9-bit fraction. An adder butterfly folds mirrored sample pairs into sums and differences. It then splits the sum side once more into an even-even pair and an even-odd pair, and merges the even-even pair into one word for Z0. From these terms, a bit-serial style of distributed arithmetic is laid out flat: for every coefficient bit position there is one word, which is the signed sum of the terms whose weight has that bit set.

Each output has its own shift-add tree, and all eight trees work at once. A tree aligns its nine bit-level words in a single cycle and sums them. Bits below a small number of guard bits are dropped, and a fixed bias computed at elaboration puts back the average carry that was lost. The result is then rounded to an integer.

Output Z0 carries the 1/√2 weight. The common factor 1/2 of the transform is left out, so every coefficient comes out twice its normalised value.

A new sample set can be accepted on every clock cycle. The pipeline has two stages: the butterfly and bit-level sums, then the trees. `out_valid` follows `in_valid` with a fixed delay of two cycles.

Top module: `dct8_da_core`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is low after the next edge and high after the second one, carrying that set's coefficients. Sets offered on consecutive cycles come out on consecutive cycles. `out_valid` is never high without a matching input.
- R2: Sample i is the two's-complement byte `in_samples[8i+7:8i]`. Coefficient Zk is the two's-complement 11-bit field `out_coefs[11k+10:11k]`. Z0 lies within 2 of (x0+…+x7)/√2.
- R3: Z4 lies within 2 of Σ xn·cos((2n+1)·4π/16).
- R4: Z2 and Z6 each lie within 2 of Σ xn·cos((2n+1)kπ/16).
- R5: Z1, Z3, Z5 and Z7 each lie within 2 of Σ xn·cos((2n+1)kπ/16).
- R6: Let q(m) be the signed integer nearest 512·cos(mπ/16), with halves rounded away from zero. With 4 guard bits, every Zk lies within 11/16 of Σ xn·q((2n+1)k)/512. For k = 0 the reference is instead q(4)·Σxn/512.
- R7: If the input is mirror-symmetric (xi = x7−i for every i), Z1, Z3, Z5 and Z7 are exactly 0.
- R8: While `in_valid` is low, whatever is on `in_samples` has no effect. `out_coefs` keeps the last result.
- R9: Full-scale inputs do not overflow. All samples −128 gives Z0 = −724 exactly, and all samples 127 gives Z0 = 718 exactly. In both cases every other coefficient is 0.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_coefs` is all zeros, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the sample set on `in_samples` |
| in_samples | input | 8·IN_W | Eight signed samples; sample i in bits [IN_W·i+IN_W−1 : IN_W·i] |
| out_valid | output | 1 | High for one cycle per finished coefficient set |
| out_coefs | output | 8·OUT_W | Eight signed coefficients; Zk in bits [OUT_W·k+OUT_W−1 : OUT_W·k] |

## Verification
The bench builds the block with IN_W = 8 and GUARD = 4. This gives 11-bit terms and outputs, and in every tree five of the nine bit-level words lose bits, so the compensation bias is 2 least-significant guard units. At these values a full-scale sample set fits within the vector table. This means the widest sums (all −128, a ±128 split across the mirror line) and the exact rounding of Z0 for both full-scale signs can be checked against hand-computed integers. The bench also compares each coefficient with a floating-point transform and with a quantised-weight reference of its own. The second comparison separates weight rounding from tree error.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int NPT   = 8;  // points per transform
  localparam int NTERM = 4;  // butterfly terms feeding one output
  localparam int CF    = 9;  // fractional bits of every cosine weight

  // round(512 * cos(m*pi/16)) for m = 1..7; other entries unused
  function automatic int cos_code(input int m);
    int r;
    case (m)
      1: r = 502;
      2: r = 473;
      3: r = 426;
      4: r = 362;
      5: r = 284;
      6: r = 196;
      7: r = 100;
      default: r = 0;
    endcase
    return r;
  endfunction

  // signed weight of cos(m*pi/16) for any m >= 0, folded into the first octant
  function automatic int fold_code(input int m0);
    int m;
    m = m0 % 32;
    if (m <= 8)       return cos_code(m);
    else if (m <= 16) return -cos_code(16 - m);
    else if (m <= 24) return -cos_code(m - 16);
    else              return cos_code(32 - m);
  endfunction

  // weight applied to butterfly term i when forming output k
  function automatic int coef_code(input int k, input int i);
    if (k == 0)     return (i == 0) ? cos_code(4) : 0;
    if (k % 2 == 0) return (i < 2) ? fold_code((2 * i + 1) * k) : 0;
    return fold_code((2 * i + 1) * k);
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // number of bit-level words that lose bits below the guard point
  function automatic int trunc_words(input int g);
    return (CF > g) ? CF - g : 0;
  endfunction

  // average carry lost by the dropped bits, in guard units
  function automatic int tree_bias(input int g);
    return trunc_words(g) / 2;
  endfunction

  // worst-case tree deviation, in units of 2^-CF
  function automatic int tree_bound(input int g);
    return (1 << (CF - 1)) + (tree_bias(g) + 1) * (1 << (CF - g));
  endfunction

endpackage

// File: rtl/dct8_butterfly.sv
module dct8_butterfly
  import dct8_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int TW   = IN_W + 3
) (
  input  logic [NPT*IN_W-1:0]   samples,
  output logic signed [TW-1:0]  tsel [NPT][NTERM]
);

  logic signed [IN_W-1:0] x   [NPT];
  logic signed [TW-1:0]   ps  [NTERM];  // mirrored-pair sums
  logic signed [TW-1:0]   pd  [NTERM];  // mirrored-pair differences
  logic signed [TW-1:0]   ee0, ee1, eo0, eo1, a_sum;

  for (genvar n = 0; n < NPT; n++) begin : g_unpack
    assign x[n] = samples[n*IN_W +: IN_W];
  end

  for (genvar i = 0; i < NTERM; i++) begin : g_fold
    assign ps[i] = TW'(x[i]) + TW'(x[NPT-1-i]);
    assign pd[i] = TW'(x[i]) - TW'(x[NPT-1-i]);
  end

  // even section split into even-even and even-odd halves
  assign ee0   = ps[0] + ps[3];
  assign ee1   = ps[1] + ps[2];
  assign eo0   = ps[0] - ps[3];
  assign eo1   = ps[1] - ps[2];
  assign a_sum = ee0 + ee1;

  always_comb begin
    for (int k = 0; k < NPT; k++) begin
      for (int i = 0; i < NTERM; i++) begin
        tsel[k][i] = '0;
      end
    end
    tsel[0][0] = a_sum;
    tsel[4][0] = ee0;
    tsel[4][1] = ee1;
    tsel[2][0] = eo0;
    tsel[2][1] = eo1;
    tsel[6][0] = eo0;
    tsel[6][1] = eo1;
    for (int k = 1; k < NPT; k += 2) begin
      for (int i = 0; i < NTERM; i++) begin
        tsel[k][i] = pd[i];
      end
    end
  end

endmodule

// File: rtl/dct8_da_pe.sv
module dct8_da_pe
  import dct8_pkg::*;
#(
  parameter int TW = 11,
  parameter int YW = TW + 2,
  parameter int K  = 0
) (
  input  logic signed [TW-1:0] terms [NTERM],
  output logic signed [YW-1:0] words [CF]
);

  localparam int CODE [NTERM] = '{coef_code(K, 0), coef_code(K, 1),
                                  coef_code(K, 2), coef_code(K, 3)};

  logic signed [YW-1:0] acc;

  // words[j-1] carries weight 2^-j: the signed sum of the terms whose
  // weight magnitude has bit (CF-j) set
  always_comb begin
    for (int j = 1; j <= CF; j++) begin
      acc = '0;
      for (int i = 0; i < NTERM; i++) begin
        if (((abs_i(CODE[i]) >> (CF - j)) & 1) == 1) begin
          if (CODE[i] < 0) acc = acc - YW'(terms[i]);
          else             acc = acc + YW'(terms[i]);
        end
      end
      words[j-1] = acc;
    end
  end

endmodule

// File: rtl/dct8_ecat.sv
module dct8_ecat
  import dct8_pkg::*;
#(
  parameter int YW = 13,
  parameter int OW = 11,
  parameter int G  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_en,
  input  logic signed [YW-1:0] words [CF],
  output logic signed [OW-1:0] coef
);

  localparam int AW    = YW + G + 4;
  localparam int BIAS  = tree_bias(G);
  localparam int HALF  = (1 << G) >> 1;
  localparam int EW    = YW + CF + 2;
  localparam int BOUND = tree_bound(G);
  localparam logic signed [EW-1:0] BND = EW'(BOUND);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] w;

  // all words aligned in parallel; bits below the guard point dropped,
  // then bias for the lost carries plus half an LSB for rounding
  always_comb begin
    acc = AW'(BIAS + HALF);
    for (int j = 1; j <= CF; j++) begin
      w   = AW'(words[j-1]);
      w   = w <<< G;
      w   = w >>> j;
      acc = acc + w;
    end
  end

  assign coef = OW'(acc >>> G);

  // exact value of the same words, for the accuracy check below
  logic signed [EW-1:0] exact;
  logic signed [EW-1:0] scaled;
  logic signed [EW-1:0] dev;

  always_comb begin
    exact = '0;
    for (int j = 1; j <= CF; j++) begin
      exact = exact + (EW'(words[j-1]) <<< (CF - j));
    end
  end

  assign scaled = EW'(coef) <<< CF;
  assign dev    = scaled - exact;

  AST_TREE_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ((dev <= BND) && (dev >= -BND)))
    else $error("tree deviation out of bound"); // R6

endmodule

// File: rtl/dct8_da_core.sv
module dct8_da_core
  import dct8_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int GUARD = 4,
  parameter int OUT_W = IN_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NPT*IN_W-1:0]   in_samples,
  output logic                  out_valid,
  output logic [NPT*OUT_W-1:0]  out_coefs
);

  localparam int TW = IN_W + 3;
  localparam int YW = TW + 2;
  localparam int HW = NPT / 2;

  logic signed [TW-1:0]    bf_terms [NPT][NTERM];
  logic signed [YW-1:0]    y_d      [NPT][CF];
  logic signed [YW-1:0]    y_q      [NPT][CF];
  logic signed [OUT_W-1:0] z_d      [NPT];
  logic signed [OUT_W-1:0] z_q      [NPT];
  logic                    v1;
  logic                    mirror_d, mirror_q;

  dct8_butterfly #(.IN_W(IN_W), .TW(TW)) u_bfly (
    .samples (in_samples),
    .tsel    (bf_terms)
  );

  for (genvar k = 0; k < NPT; k++) begin : g_lane
    dct8_da_pe #(.TW(TW), .YW(YW), .K(k)) u_pe (
      .terms (bf_terms[k]),
      .words (y_d[k])
    );
    dct8_ecat #(.YW(YW), .OW(OUT_W), .G(GUARD)) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (v1),
      .words  (y_q[k]),
      .coef   (z_d[k])
    );
    assign out_coefs[k*OUT_W +: OUT_W] = z_q[k];
  end

  // event: input set is symmetric about its centre
  always_comb begin
    mirror_d = 1'b1;
    for (int i = 0; i < HW; i++) begin
      if (in_samples[i*IN_W +: IN_W] != in_samples[(NPT-1-i)*IN_W +: IN_W])
        mirror_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
      mirror_q  <= 1'b0;
      for (int k = 0; k < NPT; k++) begin
        z_q[k] <= '0;
        for (int j = 0; j < CF; j++) y_q[k][j] <= '0;
      end
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) begin
        y_q      <= y_d;
        mirror_q <= mirror_d;
      end
      if (v1) z_q <= z_d;
    end
  end

  logic odd_all_zero;
  assign odd_all_zero = (z_q[1] == '0) && (z_q[3] == '0) &&
                        (z_q[5] == '0) && (z_q[7] == '0);

  AST_LAT_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1) else $error("stage 1 missed a set"); // R1
  AST_LAT_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid) else $error("stage 2 missed a set"); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> !out_valid) else $error("spurious out_valid"); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(out_coefs)) else $error("result changed while idle"); // R8
  AST_MIRROR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && mirror_q) |=> odd_all_zero) else $error("odd part not zero"); // R7

endmodule

// File: tb/dct8_da_core_test.sv
module dct8_da_core_test;

  localparam int  CLK_PERIOD = 10;
  localparam int  IN_W   = 8;
  localparam int  GUARD  = 4;
  localparam int  OUT_W  = IN_W + 3;
  localparam real TOL    = 2.0;
  localparam real TOL_R6 = 0.6875;
  localparam real PI     = 3.14159265358979323846;
  localparam int  NVEC   = 10;

  // sample i in byte i (bits 8i+7:8i)
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0000_0000_0000_0000,
    64'h7F7F_7F7F_7F7F_7F7F,
    64'h8080_8080_8080_8080,
    64'h0706_0504_0302_0100,
    64'h0000_0000_0000_0064,
    64'h807F_807F_807F_807F,
    64'h0A14_1E28_281E_140A,
    64'h9C3F_E271_05B8_6DA4,
    64'h8080_8080_7F7F_7F7F,
    64'h1234_5678_9ABC_DEF0
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic [8*IN_W-1:0]     in_samples = '0;
  logic                  out_valid;
  logic [8*OUT_W-1:0]    out_coefs;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct8_da_core #(.IN_W(IN_W), .GUARD(GUARD), .OUT_W(OUT_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_samples (in_samples),
    .out_valid  (out_valid),
    .out_coefs  (out_coefs)
  );

  function automatic int smp(input logic [63:0] v, input int n);
    logic signed [7:0] b;
    b = v[n*8 +: 8];
    return int'(b);
  endfunction

  function automatic int get_z(input int k);
    logic signed [OUT_W-1:0] zz;
    zz = out_coefs[k*OUT_W +: OUT_W];
    return int'(zz);
  endfunction

  function automatic real rabs(input real a);
    return (a < 0.0) ? -a : a;
  endfunction

  // floating-point transform, 1/2 factor omitted, 1/sqrt2 on Z0
  function automatic real ref_dct(input int k, input logic [63:0] v);
    real s;
    s = 0.0;
    for (int n = 0; n < 8; n++) s += smp(v, n) * $cos((2*n+1) * k * PI / 16.0);
    if (k == 0) s = s / $sqrt(2.0);
    return s;
  endfunction

  function automatic int qw(input int m);
    real c;
    int  mag;
    c   = $cos(m * PI / 16.0);
    mag = int'($floor(rabs(c) * 512.0 + 0.5));
    return (c < 0.0) ? -mag : mag;
  endfunction

  // same transform with 9-bit quantised weights, kept exact
  function automatic real ref_quant(input int k, input logic [63:0] v);
    int acc;
    acc = 0;
    if (k == 0) begin
      for (int n = 0; n < 8; n++) acc += smp(v, n);
      acc = acc * qw(4);
    end else begin
      for (int n = 0; n < 8; n++) acc += smp(v, n) * qw((2*n+1) * k);
    end
    return acc / 512.0;
  endfunction

  function automatic string ktag(input int k);
    if (k == 0) return "R2";
    if (k == 4) return "R3";
    if (k == 2 || k == 6) return "R4";
    return "R5";
  endfunction

  task automatic chk_int(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_set(input logic [63:0] v);
    bit mir;
    for (int k = 0; k < 8; k++) begin
      int  z;
      real r, q;
      z = get_z(k);
      r = ref_dct(k, v);
      q = ref_quant(k, v);
      n_chk++;
      if (rabs(z - r) > TOL) begin
        n_fail++;
        $display("FAIL %s Z%0d: got %0d expected %f (+-2)", ktag(k), k, z, r);
      end
      n_chk++;
      if (rabs(z - q) > TOL_R6) begin
        n_fail++;
        $display("FAIL R6 Z%0d: got %0d expected %f (+-11/16)", k, z, q);
      end
    end
    mir = 1'b1;
    for (int i = 0; i < 4; i++) if (smp(v, i) != smp(v, 7 - i)) mir = 1'b0;
    if (mir) begin
      for (int k = 1; k < 8; k += 2) chk_int("R7", $sformatf("Z%0d mirror", k), get_z(k), 0);
    end
  endtask

  task automatic run_vec(input logic [63:0] v);
    logic [8*OUT_W-1:0] snap;
    @(negedge clk);
    in_samples = v;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
    in_samples = ~v;  // junk while idle, must be ignored
    chk_int("R1", "out_valid one cycle in", int'(out_valid), 0);
    @(negedge clk);
    chk_int("R1", "out_valid two cycles in", int'(out_valid), 1);
    chk_set(v);
    snap = out_coefs;
    @(negedge clk);
    chk_int("R1", "out_valid pulse ends", int'(out_valid), 0);
    in_samples = 64'h5A5A_A5A5_3C3C_C3C3;
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (out_coefs !== snap) begin
      n_fail++;
      $display("FAIL R8 hold: got %h expected %h", out_coefs, snap);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got no completion expected finish within 20000 cycles");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset dominates live inputs
    in_valid   = 1'b1;
    in_samples = VEC[1];
    repeat (3) @(negedge clk);
    chk_int("R10", "out_valid in reset", int'(out_valid), 0);
    chk_int("R10", "out_coefs in reset", int'(out_coefs != '0), 0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_int("R1", "no output after reset", int'(out_valid), 0);

    // table walk
    for (int t = 0; t < NVEC; t++) run_vec(VEC[t]);

    // R9: full-scale exact values
    run_vec(VEC[2]);
    chk_int("R9", "Z0 all -128", get_z(0), -724);
    for (int k = 1; k < 8; k++) chk_int("R9", $sformatf("Z%0d all -128", k), get_z(k), 0);
    run_vec(VEC[1]);
    chk_int("R9", "Z0 all 127", get_z(0), 718);
    for (int k = 1; k < 8; k++) chk_int("R9", $sformatf("Z%0d all 127", k), get_z(k), 0);

    // R1: back-to-back sets come out on consecutive cycles
    @(negedge clk);
    in_samples = VEC[3];
    in_valid   = 1'b1;
    @(negedge clk);
    in_samples = VEC[7];
    @(negedge clk);
    chk_int("R1", "stream first", int'(out_valid), 1);
    chk_set(VEC[3]);
    in_samples = VEC[9];
    @(negedge clk);
    in_valid = 1'b0;
    chk_int("R1", "stream second", int'(out_valid), 1);
    chk_set(VEC[7]);
    @(negedge clk);
    chk_int("R1", "stream third", int'(out_valid), 1);
    chk_set(VEC[9]);
    @(negedge clk);
    chk_int("R1", "stream ends", int'(out_valid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule